// File: doc/BRIEF.md
# Interleaved Memory Port Address Decoder

This block sits on one port of a shared, word-addressed memory module and decides, for every request that arrives on that port, whether the request targets this module. When it does, the block also forms the 14-bit word index used inside the module's 16K-word store. The port can be switched off. It carries its own base-address setting. It can be told whether the module is one of two or four modules that share the address space word by word, and which slot in that rotation it occupies.

Addresses follow big-endian bit numbering: a full 22-bit address runs from bit 14 (most significant) to bit 35 (least significant). On the `req_addr` vector, element `k` carries address bit `35-k`. A narrow-bus setting drops the four most significant address bits (bits 14 to 17) from the comparison, so the same decoder also serves an 18-bit bus. The decision logic is purely combinational. A parameter adds a registered output stage, which is on by default.

Top module: `mport_addr_decode`

## Requirements
- R1: `req_addr[k]` carries big-endian address bit `35-k`, so `req_addr[0]` is bit 35 (least significant) and `req_addr[21:18]` are bits 14 to 17.
- R2: While `port_en` is 0, `hit` is 0 and `word_idx` is 0, whatever the other inputs are.
- R3: With `ilv_mode` = 2'b00 (no interleave), a hit requires `req_addr[21:14]` == `base_sel[7:0]`, and `word_idx` = `req_addr[13:0]`.
- R4: With `ilv_mode` = 2'b01 (two-way), a hit requires `req_addr[0]` == `ilv_sel[0]` and `req_addr[21:15]` == `base_sel[7:1]`; `base_sel[0]` is ignored and `word_idx` = `req_addr[14:1]`.
- R5: With `ilv_mode` = 2'b10 (four-way), a hit requires `req_addr[1:0]` == `ilv_sel[1:0]` and `req_addr[21:16]` == `base_sel[7:2]`; `base_sel[1:0]` are ignored and `word_idx` = `req_addr[15:2]`.
- R6: While `narrow_bus` is 1, `req_addr[21:18]` and `base_sel[7:4]` take no part in the base comparison, in every interleave mode.
- R7: `ilv_mode` = 2'b11 is reserved and never produces a hit.
- R8: Whenever `hit` is 0, `word_idx` is 0.
- R9: With the registered stage (default), `hit` and `word_idx` reflect the inputs sampled at the previous rising clock edge. A synchronous active-low reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable; 0 blocks every hit |
| narrow_bus | input | 1 | 1 drops address bits 14 to 17 from the base comparison |
| base_sel | input | 8 | Module base setting, aligned with `req_addr[21:14]` |
| ilv_mode | input | 2 | 00 none, 01 two-way, 10 four-way, 11 reserved |
| ilv_sel | input | 2 | Interleave slot; bit 0 matches address bit 35, bit 1 matches bit 34 |
| req_addr | input | 22 | Request address, element k = big-endian bit 35-k |
| hit | output | 1 | Request selects this module |
| word_idx | output | 14 | Word index inside the module, 0 when no hit |

## Verification
The bound checker watches, on every clock, the properties that follow from a single input cycle. These are the blocking by the enable, the reserved mode, slot mismatches in both interleave modes, the index taken in the plain mode and the zero index on a miss. Base matching under the narrow-bus setting, the ignored low base bits in the interleaved modes and the clearing by reset can only be shown by the bench's scenarios. The bench's behavioural model predicts these with integer division and modulo, and it compares its prediction against both outputs one cycle after each input set.

// File: rtl/mpd_pkg.sv
// Package mpd_pkg
// Shared type for the port address decoder: the interleave mode encoding.
// Assumes the two-bit encoding below is what the configuration supplies.
package mpd_pkg;

    typedef enum logic [1:0] {
        ILV_NONE = 2'b00,
        ILV_TWO  = 2'b01,
        ILV_FOUR = 2'b10,
        ILV_RSVD = 2'b11
    } ilv_mode_e;

    // number of low address bits consumed by each interleave mode
    function automatic int unsigned ilv_shift(input ilv_mode_e m);
        case (m)
            ILV_TWO:  return 1;
            ILV_FOUR: return 2;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/mpd_index_sel.sv
// Module mpd_index_sel
// Forms the local word index by dropping the low address bits that the
// interleave mode consumes. Assumes ADDR_W >= IDX_W + SEL_W so every
// shifted window stays inside the address.
module mpd_index_sel
    import mpd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int IDX_W  = 14,
    parameter int SEL_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  ilv_mode_e         mode,
    output logic [IDX_W-1:0]  idx
);

    localparam int NWAYS = SEL_W + 1;

    logic [IDX_W-1:0] window [NWAYS];

    // one candidate window per possible shift amount
    for (genvar s = 0; s < NWAYS; s++) begin : g_win
        assign window[s] = addr[s +: IDX_W];
    end

    // pick the window matching the active interleave mode
    always_comb begin
        case (mode)
            ILV_NONE: idx = window[0];
            ILV_TWO:  idx = window[1];
            ILV_FOUR: idx = window[SEL_W];
            default:  idx = '0;
        endcase
    end

endmodule

// File: rtl/mpd_slot_match.sv
// Module mpd_slot_match
// Compares the low address bits consumed by interleaving against the slot
// switches. Assumes slot bit j lines up with address vector bit j.
module mpd_slot_match
    import mpd_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] addr_low,
    input  logic [SEL_W-1:0] slot,
    input  ilv_mode_e        mode,
    output logic             slot_ok,
    output logic             mode_ok
);

    logic [SEL_W-1:0] care;
    logic [SEL_W-1:0] bit_ok;

    // bits that take part in the slot match for this mode
    always_comb begin
        for (int j = 0; j < SEL_W; j++) begin
            care[j] = (j < int'(ilv_shift(mode)));
        end
    end

    for (genvar j = 0; j < SEL_W; j++) begin : g_bit
        assign bit_ok[j] = !care[j] || (addr_low[j] == slot[j]);
    end

    assign slot_ok = &bit_ok;
    assign mode_ok = (mode != ILV_RSVD);

endmodule

// File: rtl/mpd_base_match.sv
// Module mpd_base_match
// Compares the address field above the index against the base setting,
// masking low bits that interleaving uses for the index and, on a narrow
// bus, the top NARROW_W bits. Assumes base bit i lines up with address
// bit IDX_W+i.
module mpd_base_match
    import mpd_pkg::*;
#(
    parameter int BASE_W   = 8,
    parameter int NARROW_W = 4
) (
    input  logic [BASE_W-1:0] addr_hi,
    input  logic [BASE_W-1:0] base,
    input  ilv_mode_e         mode,
    input  logic              narrow,
    output logic              base_ok
);

    localparam int WIDE_LIM = BASE_W - NARROW_W;

    logic [BASE_W-1:0] care;
    logic [BASE_W-1:0] bit_ok;

    // mask: drop bits below the interleave shift and, if narrow, the top bits
    always_comb begin
        for (int i = 0; i < BASE_W; i++) begin
            care[i] = (i >= int'(ilv_shift(mode))) && !(narrow && (i >= WIDE_LIM));
        end
    end

    for (genvar i = 0; i < BASE_W; i++) begin : g_bit
        assign bit_ok[i] = !care[i] || (addr_hi[i] == base[i]);
    end

    assign base_ok = &bit_ok;

endmodule

// File: rtl/mpd_out_stage.sv
// Module mpd_out_stage
// Optional output register for the decode result. REG_OUT=1 registers both
// outputs with a synchronous active-low reset; REG_OUT=0 passes them through.
module mpd_out_stage #(
    parameter int IDX_W   = 14,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_d,
    input  logic [IDX_W-1:0] idx_d,
    output logic             hit_q,
    output logic [IDX_W-1:0] idx_q
);

    if (REG_OUT) begin : g_reg
        // capture the decode result once per clock, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_q <= 1'b0;
                idx_q <= '0;
            end else begin
                hit_q <= hit_d;
                idx_q <= idx_d;
            end
        end
    end else begin : g_comb
        assign hit_q = hit_d;
        assign idx_q = idx_d;
    end

endmodule

// File: rtl/mport_addr_decode.sv
// Module mport_addr_decode
// Address decoder for one port of a shared word-addressed memory module.
// Decides whether a request selects this module and forms the local word
// index. Assumes big-endian numbering on the bus: req_addr[k] carries bit
// 35-k, so req_addr[0] is the least significant address bit.
module mport_addr_decode
    import mpd_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int IDX_W    = 14,
    parameter int SEL_W    = 2,
    parameter int NARROW_W = 4,
    parameter bit REG_OUT  = 1'b1,
    localparam int BASE_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              narrow_bus,
    input  logic [BASE_W-1:0] base_sel,
    input  logic [1:0]        ilv_mode,
    input  logic [SEL_W-1:0]  ilv_sel,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  word_idx
);

    ilv_mode_e        mode;
    logic [IDX_W-1:0] idx_raw;
    logic             slot_ok;
    logic             mode_ok;
    logic             base_ok;
    logic             hit_d;
    logic [IDX_W-1:0] idx_d;

    assign mode = ilv_mode_e'(ilv_mode);

    mpd_index_sel #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .SEL_W  (SEL_W)
    ) u_index (
        .addr (req_addr),
        .mode (mode),
        .idx  (idx_raw)
    );

    mpd_slot_match #(
        .SEL_W (SEL_W)
    ) u_slot (
        .addr_low (req_addr[SEL_W-1:0]),
        .slot     (ilv_sel),
        .mode     (mode),
        .slot_ok  (slot_ok),
        .mode_ok  (mode_ok)
    );

    mpd_base_match #(
        .BASE_W   (BASE_W),
        .NARROW_W (NARROW_W)
    ) u_base (
        .addr_hi (req_addr[ADDR_W-1:IDX_W]),
        .base    (base_sel),
        .mode    (mode),
        .narrow  (narrow_bus),
        .base_ok (base_ok)
    );

    // combine the match terms; the index is forced to zero on a miss
    always_comb begin
        hit_d = port_en && mode_ok && slot_ok && base_ok;
        idx_d = hit_d ? idx_raw : '0;
    end

    mpd_out_stage #(
        .IDX_W   (IDX_W),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_d (hit_d),
        .idx_d (idx_d),
        .hit_q (hit),
        .idx_q (word_idx)
    );

endmodule

// File: rtl/mport_addr_decode_chk.sv
// Module mport_addr_decode_chk
// Port-level checker for mport_addr_decode, bound to every instance.
// Assumes the mode encoding 00 none, 01 two-way, 10 four-way, 11 reserved.
module mport_addr_decode_chk #(
    parameter int ADDR_W  = 22,
    parameter int IDX_W   = 14,
    parameter int SEL_W   = 2,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic [1:0]        ilv_mode,
    input logic [SEL_W-1:0]  ilv_sel,
    input logic [ADDR_W-1:0] req_addr,
    input logic              hit,
    input logic [IDX_W-1:0]  word_idx
);

    // R8: a miss always shows a zero index
    assert_zero_idx_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (word_idx == '0));

    if (REG_OUT) begin : g_reg
        assert_disabled_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !port_en |=> !hit);
        assert_reserved_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ilv_mode == 2'b11) |=> !hit);
        assert_two_way_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ilv_mode == 2'b01 && req_addr[0] != ilv_sel[0]) |=> !hit);
        assert_four_way_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ilv_mode == 2'b10 && req_addr[1:0] != ilv_sel[1:0]) |=> !hit);
        assert_plain_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ilv_mode == 2'b00) |=> (!hit || word_idx == $past(req_addr[IDX_W-1:0])));
    end else begin : g_comb
        assert_disabled_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !port_en |-> !hit);
        assert_reserved_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ilv_mode == 2'b11) |-> !hit);
        assert_two_way_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ilv_mode == 2'b01 && req_addr[0] != ilv_sel[0]) |-> !hit);
        assert_four_way_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ilv_mode == 2'b10 && req_addr[1:0] != ilv_sel[1:0]) |-> !hit);
        assert_plain_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ilv_mode == 2'b00) |-> (!hit || word_idx == req_addr[IDX_W-1:0]));
    end

endmodule

bind mport_addr_decode mport_addr_decode_chk #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .SEL_W   (SEL_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .ilv_mode (ilv_mode),
    .ilv_sel  (ilv_sel),
    .req_addr (req_addr),
    .hit      (hit),
    .word_idx (word_idx)
);

// File: tb/mport_addr_decode_bench.sv
// Bench for mport_addr_decode (default parameters, registered output).
// Inputs are driven on the falling edge. The outputs seen at each falling
// edge are compared with a behavioural prediction for the inputs that were
// latched at the rising edge in between.
module mport_addr_decode_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 22;
    localparam int IDX_W      = 14;
    localparam int BASE_W     = ADDR_W - IDX_W;
    localparam int IDX_SPAN   = 1 << IDX_W;
    localparam int N_RANDOM   = 400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              port_en = 1'b0;
    logic              narrow_bus = 1'b0;
    logic [BASE_W-1:0] base_sel = '0;
    logic [1:0]        ilv_mode = 2'b00;
    logic [1:0]        ilv_sel = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              hit;
    logic [IDX_W-1:0]  word_idx;

    int    checks = 0;
    int    failures = 0;
    bit    exp_hit = 1'b0;
    int    exp_idx = 0;
    string exp_tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    mport_addr_decode u_mport_addr_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_en    (port_en),
        .narrow_bus (narrow_bus),
        .base_sel   (base_sel),
        .ilv_mode   (ilv_mode),
        .ilv_sel    (ilv_sel),
        .req_addr   (req_addr),
        .hit        (hit),
        .word_idx   (word_idx)
    );

    // behavioural prediction with integer division and modulo
    function automatic void predict(input bit en, input bit nar, input int base,
                                    input int mode, input int sel, input int addr,
                                    output bit h, output int idx);
        int ways, lg, upper, span;
        h = 1'b0;
        idx = 0;
        if (!en || mode == 3) return;
        ways = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
        lg = (mode == 0) ? 0 : (mode == 1) ? 1 : 2;
        if ((addr % ways) != (sel % ways)) return;
        upper = addr / (IDX_SPAN * ways);
        span = nar ? (1 << (BASE_W - 4 - lg)) : (1 << (BASE_W - lg));
        if ((upper % span) != ((base / ways) % span)) return;
        h = 1'b1;
        idx = (addr / ways) % IDX_SPAN;
    endfunction

    task automatic compare();
        checks++;
        if (hit !== exp_hit) begin
            failures++;
            $display("FAIL %s hit: actual=%0b expected=%0b", exp_tag, hit, exp_hit);
        end
        checks++;
        if (int'(word_idx) != exp_idx || $isunknown(word_idx)) begin
            failures++;
            $display("FAIL %s word_idx: actual=%0h expected=%0h", exp_tag, word_idx, exp_idx);
        end
    endtask

    // at a falling edge: check the previous prediction, then drive a new vector
    task automatic step(input string tag, input bit rst, input bit en, input bit nar,
                        input int base, input int mode, input int sel, input int addr);
        bit h;
        int i;
        @(negedge clk);
        compare();
        rst_n = rst;
        port_en = en;
        narrow_bus = nar;
        base_sel = BASE_W'(base);
        ilv_mode = 2'(mode);
        ilv_sel = 2'(sel);
        req_addr = ADDR_W'(addr);
        predict(en, nar, base, mode, sel, addr, h, i);
        exp_hit = rst ? h : 1'b0;
        exp_idx = rst ? i : 0;
        exp_tag = rst ? tag : "R9";
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stimulus
        // reset state with a vector that would otherwise hit (R9)
        step("R9", 1'b0, 1'b1, 1'b0, 8'h5A, 0, 0, 22'h16_9234);
        step("R9", 1'b0, 1'b1, 1'b0, 8'h5A, 0, 0, 22'h16_9234);
        // plain mode hit and base mismatch (R3)
        step("R3", 1'b1, 1'b1, 1'b0, 8'h5A, 0, 0, (8'h5A << 14) | 14'h1234);
        step("R3", 1'b1, 1'b1, 1'b0, 8'h5A, 0, 0, (8'h5B << 14) | 14'h1234);
        // disabled port blocks a matching request (R2)
        step("R2", 1'b1, 1'b0, 1'b0, 8'h5A, 0, 0, (8'h5A << 14) | 14'h1234);
        // two-way: bit 35 is req_addr[0] (R1); base bit 0 ignored (R4)
        step("R1", 1'b1, 1'b1, 1'b0, 8'h5A, 1, 1, (8'h5B << 14) | 14'h2469);
        step("R4", 1'b1, 1'b1, 1'b0, 8'h5B, 1, 1, (8'h5A << 14) | 14'h2469);
        step("R4", 1'b1, 1'b1, 1'b0, 8'h5A, 1, 0, (8'h5A << 14) | 14'h2469);
        step("R4", 1'b1, 1'b1, 1'b0, 8'h5A, 1, 1, (8'h58 << 14) | 14'h2469);
        // four-way: slot on req_addr[1:0], base bits 1:0 ignored (R5)
        step("R5", 1'b1, 1'b1, 1'b0, 8'h5B, 2, 2, (8'h58 << 14) | 14'h3FFE);
        step("R5", 1'b1, 1'b1, 1'b0, 8'h5B, 2, 2, (8'h58 << 14) | 14'h3FFD);
        step("R5", 1'b1, 1'b1, 1'b0, 8'h5B, 2, 1, (8'h50 << 14) | 14'h0001);
        // narrow bus drops the top four bits (R6), in every mode
        step("R6", 1'b1, 1'b1, 1'b1, 8'h0A, 0, 0, (8'hFA << 14) | 14'h0777);
        step("R6", 1'b1, 1'b1, 1'b0, 8'h0A, 0, 0, (8'hFA << 14) | 14'h0777);
        step("R6", 1'b1, 1'b1, 1'b1, 8'h3B, 1, 0, (8'hCA << 14) | 14'h0010);
        step("R6", 1'b1, 1'b1, 1'b1, 8'h77, 2, 3, (8'h84 << 14) | 14'h0013);
        // reserved mode never hits (R7)
        step("R7", 1'b1, 1'b1, 1'b0, 8'h5A, 3, 0, (8'h5A << 14) | 14'h1234);
        step("R7", 1'b1, 1'b1, 1'b1, 8'h00, 3, 3, 0);
        // mid-run reset clears a hitting result (R9)
        step("R3", 1'b1, 1'b1, 1'b0, 8'h01, 0, 0, (8'h01 << 14) | 14'h0042);
        step("R9", 1'b0, 1'b1, 1'b0, 8'h01, 0, 0, (8'h01 << 14) | 14'h0042);
        // random sweep, half of the addresses aimed at the base (R8 on misses)
        for (int n = 0; n < N_RANDOM; n++) begin
            int    base, mode, sel, addr;
            bit    en, nar;
            string tag;
            base = int'($urandom_range(255, 0));
            mode = int'($urandom_range(3, 0));
            sel  = int'($urandom_range(3, 0));
            en   = ($urandom_range(7, 0) != 0);
            nar  = ($urandom_range(1, 0) != 0);
            addr = int'($urandom_range(22'h3F_FFFF, 0));
            if ($urandom_range(1, 0) != 0) addr = (base << 14) | (addr % IDX_SPAN);
            if ($urandom_range(1, 0) != 0) addr = (addr & ~3) | sel;
            tag = (mode == 0) ? "R3" : (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R7";
            if (!en) tag = "R2";
            step(tag, 1'b1, en, nar, base, mode, sel, addr);
        end
        // final comparison of the last vector (R8 idle)
        step("R8", 1'b1, 1'b0, 1'b0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule